// File: doc/BRIEF.md
# Time-of-Day Counter with Shadow Access

This block keeps the running time of a precision-time clock as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock edge the nanoseconds count moves forward by a fixed step chosen at build time, for example 8 ns for a 125 MHz clock. When it reaches one full second it wraps and carries into seconds. A separate frequency-trimming block can lengthen or shorten any single step by one nanosecond through two pulse inputs.

Software never touches the counter directly. It works through three shadow registers: upper seconds, lower seconds and nanoseconds. It also has a one-shot action code. A save copies the counter into the shadows in one edge, so the three halves read back form one consistent time. A load copies the shadows into the counter. A delta adds the shadow nanoseconds, taken as a signed offset, to the running time and carries or borrows into seconds as needed. The nanoseconds count may hold a value up to 16 ns below zero for a short time. Such a value is stored near the top of the 30-bit range. It reads as the previous second plus 999,999,984 ns plus its low four bits.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds and nanoseconds outputs, all three shadow registers and `act_code` are zero.
- R2: With no action and no correction pulse, `tod_ns` rises by INC_NS (8) on each clock edge. When the sum reaches 1,000,000,000, nanoseconds becomes the sum minus 1,000,000,000 and the 48-bit seconds count rises by one, carrying across bit 32.
- R3: During a cycle with `corr_up` high alone, the step is INC_NS+1. With `corr_dn` high alone the step is INC_NS-1. With both high the step is INC_NS.
- R4: A write with `wr_sel`=3 stores `wr_data[2:0]` as the action code: 0 idle, 1 save, 2 load, 3 delta, 4 clock, with 5 to 7 stored as idle. The code is visible on `act_code` for one cycle and runs at the next edge. After that `act_code` returns to 0 unless a new action is written.
- R5: At the edge where a save runs, the shadows take the counter value present just before that edge, with all 48 seconds bits and the nanoseconds taken together.
- R6: At the edge where a load runs, the counter takes the shadow seconds {upper, lower} and the shadow nanoseconds exactly, with no step added.
- R7: At the edge where a delta runs, the counter becomes the previous time plus INC_NS plus the shadow nanoseconds read as a 30-bit two's complement offset. The nanoseconds value is brought back into 0 to 999,999,999, with a carry or borrow of one second. The shadow seconds registers have no effect on a delta.
- R8: If a delta leaves nanoseconds between -16 and -1, the seconds count is not changed and nanoseconds holds 2^30 plus that value. The next ordinary step adds INC_NS to the true value and produces a non-negative nanoseconds count again.
- R9: Host writes with `wr_sel`=0 load upper seconds from `wr_data[15:0]`, with `wr_sel`=1 load lower seconds from `wr_data[31:0]`, and with `wr_sel`=2 load nanoseconds from `wr_data[29:0]`. A save at the same edge takes priority over a host shadow write.
- R10: The idle and clock codes leave the shadows unchanged and let the counter take its ordinary step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_sel | input | 2 | Write target: 0 upper seconds, 1 lower seconds, 2 nanoseconds, 3 action |
| wr_data | input | 32 | Host write data |
| corr_up | input | 1 | Lengthen this cycle's step by 1 ns |
| corr_dn | input | 1 | Shorten this cycle's step by 1 ns |
| act_code | output | 3 | Action waiting to run at the next edge |
| tod_sec | output | 48 | Live seconds count |
| tod_ns | output | 30 | Live nanoseconds count |
| shd_sec_hi | output | 16 | Shadow upper seconds |
| shd_sec_lo | output | 32 | Shadow lower seconds |
| shd_ns | output | 30 | Shadow nanoseconds |

## Verification
The bench builds the block with its defaults: a 1,000,000,000 ns second, an 8 ns step, a 16 ns negative window, correction enabled and a 48-bit seconds count. Because a full second would take far too many cycles, every rollover is reached by loading a time a few steps before the second boundary. This includes a load just below the 32-bit seconds boundary, so the carry into the upper seconds bits is also exercised. Delta offsets are chosen to land on a carry, on a borrow and inside the negative window. Each expected value is computed from the time captured just before the edge where the action runs.

// File: rtl/tod_pkg.sv
package tod_pkg;

   typedef enum logic [2:0] {
      ACT_IDLE  = 3'd0,
      ACT_SAVE  = 3'd1,
      ACT_LOAD  = 3'd2,
      ACT_DELTA = 3'd3,
      ACT_CLOCK = 3'd4
   } act_e;

   localparam logic [1:0] SEL_SEC_HI = 2'd0;
   localparam logic [1:0] SEL_SEC_LO = 2'd1;
   localparam logic [1:0] SEL_NS     = 2'd2;
   localparam logic [1:0] SEL_ACT    = 2'd3;

   function automatic act_e decode_act(input logic [2:0] code);
      act_e r;
      case (code)
         3'd1:    r = ACT_SAVE;
         3'd2:    r = ACT_LOAD;
         3'd3:    r = ACT_DELTA;
         3'd4:    r = ACT_CLOCK;
         default: r = ACT_IDLE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tod_norm.sv
module tod_norm #(
   parameter int SEC_W      = 48,
   parameter int NS_W       = 30,
   parameter int ADD_W      = 32,
   parameter int NS_PER_SEC = 1000000000,
   parameter int NEG_SPAN   = 16
) (
   input  logic [SEC_W-1:0]        sec_in,
   input  logic [NS_W-1:0]         ns_in,
   input  logic signed [ADD_W-1:0] add_in,
   output logic [SEC_W-1:0]        sec_out,
   output logic [NS_W-1:0]         ns_out
);
   localparam int CW = ADD_W + 2;
   localparam logic [NS_W-1:0]      NEG_BASE = NS_W'((64'd1 << NS_W) - 64'(NEG_SPAN));
   localparam logic signed [CW-1:0] MOD_NS   = CW'(64'd1 << NS_W);
   localparam logic signed [CW-1:0] ONE_SEC  = CW'(NS_PER_SEC);
   localparam logic signed [CW-1:0] LIM_LO   = -CW'(NEG_SPAN);

   logic signed [CW-1:0] ns_s;
   logic signed [CW-1:0] sum;
   logic signed [CW-1:0] wrapped;

   always_comb begin
      if (ns_in >= NEG_BASE) ns_s = CW'(ns_in) - MOD_NS;
      else                   ns_s = CW'(ns_in);
      sum     = ns_s + CW'(add_in);
      wrapped = sum;
      sec_out = sec_in;
      if (sum >= ONE_SEC) begin
         wrapped = sum - ONE_SEC;
         sec_out = sec_in + SEC_W'(1);
      end else if (sum < LIM_LO) begin
         wrapped = sum + ONE_SEC;
         sec_out = sec_in - SEC_W'(1);
      end
      ns_out = NS_W'(wrapped);
   end

endmodule

// File: rtl/tod_action.sv
module tod_action
   import tod_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output act_e              act
);
   always_ff @(posedge clk) begin
      if (!rst_n)                          act <= ACT_IDLE;
      else if (wr_en && wr_sel == SEL_ACT) act <= decode_act(wr_data[2:0]);
      else                                 act <= ACT_IDLE;
   end
endmodule

// File: rtl/tod_shadow.sv
module tod_shadow
   import tod_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SEC_HI_W = 16,
   parameter int NS_W     = 30
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_sel,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     save,
   input  logic [SEC_HI_W+DATA_W-1:0] snap_sec,
   input  logic [NS_W-1:0]          snap_ns,
   output logic [SEC_HI_W-1:0]      sec_hi,
   output logic [DATA_W-1:0]        sec_lo,
   output logic [NS_W-1:0]          ns
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_hi <= '0;
         sec_lo <= '0;
         ns     <= '0;
      end else if (save) begin
         sec_hi <= snap_sec[SEC_HI_W+DATA_W-1:DATA_W];
         sec_lo <= snap_sec[DATA_W-1:0];
         ns     <= snap_ns;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_SEC_HI: sec_hi <= wr_data[SEC_HI_W-1:0];
            SEL_SEC_LO: sec_lo <= wr_data;
            SEL_NS:     ns     <= wr_data[NS_W-1:0];
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/tod_core.sv
module tod_core #(
   parameter int SEC_W      = 48,
   parameter int NS_W       = 30,
   parameter int ADD_W      = 32,
   parameter int NS_PER_SEC = 1000000000,
   parameter int NEG_SPAN   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_en,
   input  logic [SEC_W-1:0]        load_sec,
   input  logic [NS_W-1:0]         load_ns,
   input  logic signed [ADD_W-1:0] addend,
   output logic [SEC_W-1:0]        sec,
   output logic [NS_W-1:0]         ns
);
   logic [SEC_W-1:0] sec_nx;
   logic [NS_W-1:0]  ns_nx;

   tod_norm #(
      .SEC_W(SEC_W), .NS_W(NS_W), .ADD_W(ADD_W),
      .NS_PER_SEC(NS_PER_SEC), .NEG_SPAN(NEG_SPAN)
   ) u_norm (
      .sec_in(sec), .ns_in(ns), .add_in(addend),
      .sec_out(sec_nx), .ns_out(ns_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec <= '0;
         ns  <= '0;
      end else if (load_en) begin
         sec <= load_sec;
         ns  <= load_ns;
      end else begin
         sec <= sec_nx;
         ns  <= ns_nx;
      end
   end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SEC_W      = 48,
   parameter int NS_W       = 30,
   parameter int NS_PER_SEC = 1000000000,
   parameter int INC_NS     = 8,
   parameter int NEG_SPAN   = 16,
   parameter bit CORR_EN    = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [1:0]                 wr_sel,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       corr_up,
   input  logic                       corr_dn,
   output logic [2:0]                 act_code,
   output logic [SEC_W-1:0]           tod_sec,
   output logic [NS_W-1:0]            tod_ns,
   output logic [SEC_W-DATA_W-1:0]    shd_sec_hi,
   output logic [DATA_W-1:0]          shd_sec_lo,
   output logic [NS_W-1:0]            shd_ns
);
   localparam int SEC_HI_W = SEC_W - DATA_W;
   localparam int ADD_W    = DATA_W;

   initial begin
      assert (SEC_W > DATA_W && SEC_W <= 2 * DATA_W)
         else $error("seconds width must lie between one and two data words");
      assert (NS_W < DATA_W && NS_W >= 30)
         else $error("nanoseconds width out of range");
      assert (INC_NS >= 2 && INC_NS < 1000)
         else $error("step must allow a one-nanosecond trim");
      assert (NEG_SPAN >= INC_NS && NEG_SPAN < 4096)
         else $error("negative window must cover one step");
   end

   act_e                    act;
   logic signed [ADD_W-1:0] corr_term;
   logic signed [ADD_W-1:0] offset;
   logic signed [ADD_W-1:0] addend;

   tod_action #(.DATA_W(DATA_W)) u_act (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .act(act)
   );

   tod_shadow #(.DATA_W(DATA_W), .SEC_HI_W(SEC_HI_W), .NS_W(NS_W)) u_shd (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .save(act == ACT_SAVE),
      .snap_sec(tod_sec), .snap_ns(tod_ns),
      .sec_hi(shd_sec_hi), .sec_lo(shd_sec_lo), .ns(shd_ns)
   );

   generate
      if (CORR_EN) begin : g_corr
         always_comb begin
            if (corr_up && !corr_dn)      corr_term = ADD_W'(1);
            else if (corr_dn && !corr_up) corr_term = -ADD_W'(1);
            else                          corr_term = '0;
         end
      end else begin : g_nocorr
         logic unused_corr;
         assign unused_corr = corr_up ^ corr_dn;
         assign corr_term   = '0;
      end
   endgenerate

   assign offset = (act == ACT_DELTA)
                   ? {{(ADD_W-NS_W){shd_ns[NS_W-1]}}, shd_ns}
                   : '0;
   assign addend = ADD_W'(INC_NS) + corr_term + offset;

   tod_core #(
      .SEC_W(SEC_W), .NS_W(NS_W), .ADD_W(ADD_W),
      .NS_PER_SEC(NS_PER_SEC), .NEG_SPAN(NEG_SPAN)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .load_en(act == ACT_LOAD),
      .load_sec({shd_sec_hi, shd_sec_lo}), .load_ns(shd_ns),
      .addend(addend), .sec(tod_sec), .ns(tod_ns)
   );

   assign act_code = act;

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
   parameter int DATA_W     = 32,
   parameter int SEC_W      = 48,
   parameter int NS_W       = 30,
   parameter int NS_PER_SEC = 1000000000,
   parameter int INC_NS     = 8,
   parameter int NEG_SPAN   = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [1:0]              wr_sel,
   input logic                    corr_up,
   input logic                    corr_dn,
   input logic [2:0]              act_code,
   input logic [SEC_W-1:0]        tod_sec,
   input logic [NS_W-1:0]         tod_ns,
   input logic [SEC_W-DATA_W-1:0] shd_sec_hi,
   input logic [DATA_W-1:0]       shd_sec_lo,
   input logic [NS_W-1:0]         shd_ns
);
   localparam logic [NS_W-1:0] NS_TOP   = NS_W'(NS_PER_SEC);
   localparam logic [NS_W-1:0] NEG_BASE = NS_W'((64'd1 << NS_W) - 64'(NEG_SPAN));
   localparam logic [NS_W-1:0] ADV_LIM  = NS_W'(NS_PER_SEC - INC_NS);

   AST_ACT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code != 3'd0 && !(wr_en && wr_sel == 2'd3)) |=> act_code == 3'd0); // R4
   AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (tod_ns < NS_TOP) || (tod_ns >= NEG_BASE)); // R8
   AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code == 3'd0 && !corr_up && !corr_dn && tod_ns < ADV_LIM)
      |=> tod_ns == $past(tod_ns) + NS_W'(INC_NS)); // R2
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code == 3'd2) |=> (tod_sec == $past({shd_sec_hi, shd_sec_lo})
                              && tod_ns == $past(shd_ns))); // R6
   AST_SAVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code == 3'd1) |=> ({shd_sec_hi, shd_sec_lo} == $past(tod_sec)
                              && shd_ns == $past(tod_ns))); // R5
   AST_SEC_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code != 3'd2 && act_code != 3'd3)
      |=> (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + SEC_W'(1))); // R2

endmodule

bind tod_counter tod_counter_chk #(
   .DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W),
   .NS_PER_SEC(NS_PER_SEC), .INC_NS(INC_NS), .NEG_SPAN(NEG_SPAN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .corr_up(corr_up), .corr_dn(corr_dn), .act_code(act_code),
   .tod_sec(tod_sec), .tod_ns(tod_ns), .shd_sec_hi(shd_sec_hi),
   .shd_sec_lo(shd_sec_lo), .shd_ns(shd_ns)
);

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
   localparam longint ONE_SEC = 64'd1000000000;
   localparam longint MOD_NS  = 64'd1 << 30;
   localparam longint NEG_LO  = MOD_NS - 16;
   localparam longint STEP    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic        corr_up = 1'b0;
   logic        corr_dn = 1'b0;
   logic [2:0]  act_code;
   logic [47:0] tod_sec;
   logic [29:0] tod_ns;
   logic [15:0] shd_sec_hi;
   logic [31:0] shd_sec_lo;
   logic [29:0] shd_ns;

   int total = 0;
   int bad   = 0;

   tod_counter u_tod_counter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .corr_up(corr_up), .corr_dn(corr_dn),
      .act_code(act_code), .tod_sec(tod_sec), .tod_ns(tod_ns),
      .shd_sec_hi(shd_sec_hi), .shd_sec_lo(shd_sec_lo), .shd_ns(shd_ns)
   );

   always #2.5 clk = ~clk;

   initial begin
      #(5.0 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string req, input string what,
                      input longint actual, input longint expected);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   task automatic host_write(input logic [1:0] sel, input logic [31:0] data);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = data;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic do_action(input logic [2:0] code,
                            output longint pre_sec, output longint pre_ns);
      host_write(2'd3, {29'd0, code});
      chk("R4", "action visible", longint'(act_code), longint'(code));
      pre_sec = longint'(tod_sec);
      pre_ns  = longint'(tod_ns);
      @(negedge clk);
      chk("R4", "action back to idle", longint'(act_code), 0);
   endtask

   task automatic model_add(input longint s, input longint n, input longint add,
                            output longint es, output longint en);
      longint t;
      t = ((n >= NEG_LO) ? n - MOD_NS : n) + add;
      if (t >= ONE_SEC) begin
         es = s + 1; en = t - ONE_SEC;
      end else if (t < -16) begin
         es = s - 1; en = t + ONE_SEC;
      end else begin
         es = s; en = (t < 0) ? t + MOD_NS : t;
      end
   endtask

   task automatic load_time(input longint s, input longint n);
      longint ps, pn;
      host_write(2'd0, 32'(s >> 32));
      host_write(2'd1, 32'(s));
      host_write(2'd2, 32'(n));
      do_action(3'd2, ps, pn);
      chk("R6", "load seconds", longint'(tod_sec), s);
      chk("R6", "load nanoseconds", longint'(tod_ns), n);
   endtask

   task automatic t_reset();
      chk("R1", "reset seconds", longint'(tod_sec), 0);
      chk("R1", "reset nanoseconds", longint'(tod_ns), 0);
      chk("R1", "reset shadow", longint'({shd_sec_hi, shd_sec_lo}) + longint'(shd_ns), 0);
      chk("R1", "reset action", longint'(act_code), 0);
      @(negedge clk);
      chk("R2", "first step", longint'(tod_ns), STEP);
   endtask

   task automatic t_rollover();
      load_time(5, 999999976);
      @(negedge clk);
      chk("R2", "step before wrap", longint'(tod_ns), 999999984);
      @(negedge clk);
      @(negedge clk);
      chk("R2", "wrap nanoseconds", longint'(tod_ns), 0);
      chk("R2", "wrap seconds", longint'(tod_sec), 6);
      load_time(64'h1_FFFF_FFFF, 999999992);
      @(negedge clk);
      chk("R2", "carry across word", longint'(tod_sec), 64'h2_0000_0000);
   endtask

   task automatic t_corr();
      longint n0;
      load_time(3, 1000);
      corr_up = 1'b1; n0 = longint'(tod_ns);
      @(negedge clk);
      corr_up = 1'b0;
      chk("R3", "step with up pulse", longint'(tod_ns), n0 + STEP + 1);
      corr_dn = 1'b1; n0 = longint'(tod_ns);
      @(negedge clk);
      corr_dn = 1'b0;
      chk("R3", "step with down pulse", longint'(tod_ns), n0 + STEP - 1);
      corr_up = 1'b1; corr_dn = 1'b1; n0 = longint'(tod_ns);
      @(negedge clk);
      corr_up = 1'b0; corr_dn = 1'b0;
      chk("R3", "both pulses cancel", longint'(tod_ns), n0 + STEP);
   endtask

   task automatic t_save();
      longint ps, pn;
      load_time(64'h1234_5678_9ABC, 123456);
      do_action(3'd1, ps, pn);
      chk("R5", "saved seconds", longint'({shd_sec_hi, shd_sec_lo}), ps);
      chk("R5", "saved nanoseconds", longint'(shd_ns), pn);
   endtask

   task automatic t_hostwrite();
      host_write(2'd0, 32'hABCD_1234);
      host_write(2'd1, 32'hDEAD_BEEF);
      host_write(2'd2, 32'hFFFF_FFFF);
      chk("R9", "upper seconds field", longint'(shd_sec_hi), 64'h1234);
      chk("R9", "lower seconds", longint'(shd_sec_lo), 64'hDEAD_BEEF);
      chk("R9", "nanoseconds field", longint'(shd_ns), 64'h3FFF_FFFF);
   endtask

   task automatic t_delta(input string req, input longint s, input longint n,
                          input longint off, input longint junk_sec);
      longint ps, pn, es, en;
      load_time(s, n);
      host_write(2'd1, 32'(junk_sec));
      host_write(2'd2, 32'(off));
      do_action(3'd3, ps, pn);
      model_add(ps, pn, STEP + off, es, en);
      chk(req, "delta seconds", longint'(tod_sec), es);
      chk(req, "delta nanoseconds", longint'(tod_ns), en);
   endtask

   task automatic t_negative();
      longint ps, pn, t_true, t_read;
      load_time(10, 0);
      host_write(2'd2, 32'(-28));
      do_action(3'd3, ps, pn);
      t_true = ps * ONE_SEC + pn + STEP - 28;
      chk("R8", "negative seconds kept", longint'(tod_sec), ps);
      chk("R8", "negative encoding", longint'(tod_ns), MOD_NS + (pn + STEP - 28));
      t_read = (longint'(tod_sec) - 1) * ONE_SEC + 999999984 + longint'(tod_ns[3:0]);
      chk("R8", "negative read rule", t_read, t_true);
      @(negedge clk);
      chk("R8", "recovered nanoseconds", longint'(tod_ns), pn + 2 * STEP - 28);
      chk("R8", "recovered seconds", longint'(tod_sec), ps);
   endtask

   task automatic t_noop();
      longint ps, pn;
      load_time(7, 5000);
      host_write(2'd2, 32'd4242);
      do_action(3'd4, ps, pn);
      chk("R10", "clock code step", longint'(tod_ns), pn + STEP);
      chk("R10", "clock code shadow", longint'(shd_ns), 4242);
      do_action(3'd0, ps, pn);
      chk("R10", "idle code step", longint'(tod_ns), pn + STEP);
      chk("R10", "idle code seconds", longint'(tod_sec), 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rollover();
      t_corr();
      t_save();
      t_hostwrite();
      t_delta("R7", 20, 999999000, 5000, 777);
      t_delta("R7", 20, 100, -1000, 999);
      t_delta("R7", 20, 500000, -200000, 1);
      t_negative();
      t_noop();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule